// File: doc/BRIEF.md
# Device Interrupt Routing Table

This block keeps one routing entry per interrupt-capable device. Each entry combines a route (the CPU to notify and the vector to hand it) with a control word (a mask bit and a pending bit). When a device pulses its interrupt line and its entry is unmasked, the block marks the entry pending and masks it. It then issues a single-cycle post carrying that entry's CPU and vector. The source stays quiet until software unmasks it again.

Software reaches the table through a simple register port with one write strobe and one read strobe. Routes live in one address window and control words in another. Each window has one 8-byte slot per device. The pending bit is cleared only by a dedicated write-one-to-clear bit, so changing the mask never loses a pending indication. When several unmasked devices fire together, the lowest device index is posted first. The others are remembered and posted on the following cycles.

Top module: `irq_route_table`

## Requirements
- R1: After reset every entry reads back mask=1, pending=0, CPU 0 and vector 0 (control word 0x4, route word 0x0), and no post or error is raised.
- R2: A route write stores wdata[12:8] as the target CPU and wdata[5:0] as the vector. A route read returns them in the same bit positions, with every other bit zero.
- R3: A control read returns the mask at bit 2 and pending at bit 0, with all other bits zero.
- R4: A control write loads the mask from wdata[2]. If wdata[1] is 1, pending is cleared; otherwise pending is unchanged. Mask falls and pending falls happen only through such writes.
- R5: A device pulse on an entry whose mask is 1 is dropped: no post is made and pending is unchanged.
- R6: A pulse on an unmasked entry sets its mask and pending bits. On the next cycle post_valid is 1 for exactly one cycle, carrying that entry's CPU and vector.
- R7: When several unmasked devices fire in the same cycle, the lowest index is posted first. Each remaining device is posted on the following cycles in ascending index order, one per cycle.
- R8: Route slot i sits at byte address ROUTE_BASE + 8*i and control slot i at CTRL_BASE + 8*i (defaults 0x000 and 0x100). The entry index is the window offset shifted right by 3.
- R9: An access to an address outside both windows, or with addr[2:0] non-zero, reads zero, changes no state, and raises reg_err for one cycle.
- R10: Read data is registered: it appears the cycle after reg_rd_en and is zero in any cycle that follows no read.
- R11: If a delivery and a control write to the same entry take effect in the same cycle, the delivery wins: the entry ends up with mask=1 and pending=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after the strobe |
| reg_err | output | 1 | One-cycle flag for an unmapped access |
| dev_irq | input | NUM_DEV | Device interrupt pulses, one bit per device |
| post_valid | output | 1 | One-cycle interrupt post |
| post_cpu | output | 5 | Target CPU of the post |
| post_vec | output | 6 | Vector of the post |

## Verification
The checker assumes that the strobes and device lines are known and held low while reset is asserted. This is because each property compares state against the previous cycle's strobes, for example that a falling mask or pending bit was caused by a write, or that an error followed an access. The bench drives every input on the falling edge, keeps all of them at zero through reset, and chooses addresses from the two windows, from the gaps between them and from unaligned offsets. Random device pulses and control writes are mixed so that same-cycle arbitration and the delivery-versus-write collision both occur often.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    // Field layout of the route word
    localparam int CPU_W   = 5;
    localparam int VEC_W   = 6;
    localparam int CPU_LSB = 8;
    localparam int VEC_LSB = 0;
    // Field layout of the control word
    localparam int MASK_BIT  = 2;
    localparam int CLEAR_BIT = 1;
    localparam int PEND_BIT  = 0;
    // Slot stride in bytes
    localparam int SLOT_SHIFT = 3;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode #(
    parameter int NUM_DEV = 8,
    parameter int ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] ROUTE_BASE = '0,
    parameter logic [ADDR_W-1:0] CTRL_BASE  = 12'h100
) (
    input  logic [ADDR_W-1:0]               addr,
    output logic                            route_hit,
    output logic                            ctrl_hit,
    output logic [$clog2(NUM_DEV)-1:0]      idx
);
    import irq_route_pkg::*;
    localparam int IDX_W = $clog2(NUM_DEV);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_DEV << SLOT_SHIFT);

    logic [ADDR_W-1:0] route_off;
    logic [ADDR_W-1:0] ctrl_off;

    always_comb begin
        // Subtraction wraps below the base, so one compare covers both ends
        route_off = addr - ROUTE_BASE;
        ctrl_off  = addr - CTRL_BASE;
        route_hit = (route_off < SPAN) && (route_off[SLOT_SHIFT-1:0] == '0);
        ctrl_hit  = (ctrl_off  < SPAN) && (ctrl_off[SLOT_SHIFT-1:0]  == '0);
        if (ctrl_hit) begin
            idx = ctrl_off[SLOT_SHIFT +: IDX_W];
        end else begin
            idx = route_off[SLOT_SHIFT +: IDX_W];
        end
    end
endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb #(
    parameter int NUM_DEV = 8
) (
    input  logic [NUM_DEV-1:0]          req,
    output logic [NUM_DEV-1:0]          grant,
    output logic [$clog2(NUM_DEV)-1:0]  grant_idx,
    output logic                        any
);
    localparam int IDX_W = $clog2(NUM_DEV);

    // Fixed priority: index 0 highest. Walk from the top so the lowest wins.
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        any       = 1'b0;
        for (int i = NUM_DEV - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant     = '0;
                grant[i]  = 1'b1;
                grant_idx = IDX_W'(i);
                any       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table #(
    parameter int NUM_DEV = 8,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter logic [ADDR_W-1:0] ROUTE_BASE = '0,
    parameter logic [ADDR_W-1:0] CTRL_BASE  = 12'h100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic                reg_rd_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                reg_err,
    input  logic [NUM_DEV-1:0]  dev_irq,
    output logic                post_valid,
    output logic [4:0]          post_cpu,
    output logic [5:0]          post_vec
);
    import irq_route_pkg::*;
    localparam int IDX_W = $clog2(NUM_DEV);

    typedef struct packed {
        logic [NUM_DEV-1:0]             mask;
        logic [NUM_DEV-1:0]             pend;
        logic [NUM_DEV-1:0]             req;
        logic [NUM_DEV-1:0][CPU_W-1:0]  cpu;
        logic [NUM_DEV-1:0][VEC_W-1:0]  vec;
        logic                           pv;
        logic [CPU_W-1:0]               pcpu;
        logic [VEC_W-1:0]               pvec;
        logic [DATA_W-1:0]              rdata;
        logic                           err;
    } state_t;

    state_t s_d, s_q;

    logic               route_hit;
    logic               ctrl_hit;
    logic [IDX_W-1:0]   acc_idx;
    logic [NUM_DEV-1:0] eligible;
    logic [NUM_DEV-1:0] grant;
    logic [IDX_W-1:0]   grant_idx;
    logic               grant_any;

    // Observed by the bound checker
    logic [NUM_DEV-1:0] mask_vec;
    logic [NUM_DEV-1:0] pend_vec;

    irq_route_decode #(
        .NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W),
        .ROUTE_BASE(ROUTE_BASE), .CTRL_BASE(CTRL_BASE)
    ) u_dec (
        .addr(reg_addr), .route_hit(route_hit), .ctrl_hit(ctrl_hit), .idx(acc_idx)
    );

    // New pulses and held losers compete, but only while unmasked
    assign eligible = (dev_irq | s_q.req) & ~s_q.mask;

    irq_route_arb #(.NUM_DEV(NUM_DEV)) u_arb (
        .req(eligible), .grant(grant), .grant_idx(grant_idx), .any(grant_any)
    );

    always_comb begin
        s_d       = s_q;
        s_d.pv    = 1'b0;
        s_d.err   = 1'b0;
        s_d.rdata = '0;

        // Reads see the state before this cycle's updates
        if (reg_rd_en) begin
            if (route_hit) begin
                s_d.rdata[CPU_LSB +: CPU_W] = s_q.cpu[acc_idx];
                s_d.rdata[VEC_LSB +: VEC_W] = s_q.vec[acc_idx];
            end else if (ctrl_hit) begin
                s_d.rdata[MASK_BIT] = s_q.mask[acc_idx];
                s_d.rdata[PEND_BIT] = s_q.pend[acc_idx];
            end else begin
                s_d.err = 1'b1;
            end
        end

        if (reg_wr_en) begin
            if (route_hit) begin
                s_d.cpu[acc_idx] = reg_wdata[CPU_LSB +: CPU_W];
                s_d.vec[acc_idx] = reg_wdata[VEC_LSB +: VEC_W];
            end else if (ctrl_hit) begin
                s_d.mask[acc_idx] = reg_wdata[MASK_BIT];
                if (reg_wdata[CLEAR_BIT]) begin
                    s_d.pend[acc_idx] = 1'b0;
                end
            end else begin
                s_d.err = 1'b1;
            end
        end

        // Losers wait for a later cycle; masked ones are forgotten
        s_d.req = eligible & ~grant;

        // Delivery overrides a same-cycle control write
        if (grant_any) begin
            s_d.mask[grant_idx] = 1'b1;
            s_d.pend[grant_idx] = 1'b1;
            s_d.pv              = 1'b1;
            s_d.pcpu            = s_q.cpu[grant_idx];
            s_d.pvec            = s_q.vec[grant_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_rdata  = s_q.rdata;
    assign reg_err    = s_q.err;
    assign post_valid = s_q.pv;
    assign post_cpu   = s_q.pcpu;
    assign post_vec   = s_q.pvec;
    assign mask_vec   = s_q.mask;
    assign pend_vec   = s_q.pend;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
    parameter int NUM_DEV = 8,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic               reg_rd_en,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               reg_err,
    input logic               post_valid,
    input logic [NUM_DEV-1:0] mask_vec,
    input logic [NUM_DEV-1:0] pend_vec
);
    import irq_route_pkg::*;
    localparam logic [DATA_W-1:0] FIELD_MASK =
        (((DATA_W'(1) << CPU_W) - 1) << CPU_LSB) | (((DATA_W'(1) << VEC_W) - 1) << VEC_LSB);

    // R4
    mask_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(mask_vec) & ~mask_vec)) |-> $past(reg_wr_en));

    // R4
    pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pend_vec) & ~pend_vec)) |-> $past(reg_wr_en));

    // R6
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_vec & ~$past(pend_vec))) |-> post_valid);

    // R6
    mask_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(mask_vec & ~$past(mask_vec))) |-> (post_valid || $past(reg_wr_en)));

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> $past(reg_rd_en || reg_wr_en));

    // R10
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_rd_en) |-> (reg_rdata == '0));

    // R2
    rdata_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~FIELD_MASK) == '0);
endmodule

bind irq_route_table irq_route_chk #(.NUM_DEV(NUM_DEV), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_rdata(reg_rdata), .reg_err(reg_err), .post_valid(post_valid),
    .mask_vec(mask_vec), .pend_vec(pend_vec)
);

// File: tb/sim_irq_route_table.sv
module sim_irq_route_table;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    logic [N-1:0] irq = '0;
    logic        pv;
    logic [4:0]  pcpu;
    logic [5:0]  pvec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state, kept from the requirements
    logic [N-1:0] m_mask, m_pend, m_req;
    logic [4:0]   m_cpu [N];
    logic [5:0]   m_vec [N];
    logic         e_pv, e_err;
    logic [4:0]   e_pcpu;
    logic [5:0]   e_pvec;
    logic [31:0]  e_rd;

    irq_route_table u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_rd_en(rd_en),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .reg_err(err),
        .dev_irq(irq), .post_valid(pv), .post_cpu(pcpu), .post_vec(pvec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // R8: 1 = route slot, 2 = control slot, 0 = unmapped
    function automatic int slot_kind(input logic [11:0] a, output int idx);
        idx = 0;
        if (a[2:0] != 3'b0) return 0;
        if (a < 12'h040) begin idx = int'(a >> 3); return 1; end
        if (a >= 12'h100 && a < 12'h140) begin idx = int'((a - 12'h100) >> 3); return 2; end
        return 0;
    endfunction

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mask = '1; m_pend = '0; m_req = '0;
        for (int i = 0; i < N; i++) begin m_cpu[i] = '0; m_vec[i] = '0; end
        e_pv = 0; e_err = 0; e_pcpu = '0; e_pvec = '0; e_rd = '0;
    endtask

    task automatic model_step();
        int k, ix, w;
        logic [N-1:0] elig;
        logic [4:0] oc;
        logic [5:0] ov;
        e_pv = 0; e_err = 0; e_rd = '0;
        if (rd_en) begin
            k = slot_kind(addr, ix);
            if (k == 1) e_rd = {19'b0, m_cpu[ix], 2'b0, m_vec[ix]};
            else if (k == 2) e_rd = {29'b0, m_mask[ix], 1'b0, m_pend[ix]};
            else e_err = 1;
        end
        elig = (irq | m_req) & ~m_mask;
        w = lowest(elig);
        if (w >= 0) begin oc = m_cpu[w]; ov = m_vec[w]; end
        else begin oc = '0; ov = '0; end
        if (wr_en) begin
            k = slot_kind(addr, ix);
            if (k == 1) begin m_cpu[ix] = wdata[12:8]; m_vec[ix] = wdata[5:0]; end
            else if (k == 2) begin
                m_mask[ix] = wdata[2];
                if (wdata[1]) m_pend[ix] = 1'b0;
            end else e_err = 1;
        end
        m_req = elig;
        if (w >= 0) begin
            m_req[w] = 1'b0;
            m_mask[w] = 1'b1; m_pend[w] = 1'b1;
            e_pv = 1; e_pcpu = oc; e_pvec = ov;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(pv == e_pv && (!e_pv || (pcpu == e_pcpu && pvec == e_pvec)), "R6/R7 post",
              {20'b0, pv, pcpu, pvec}, {20'b0, e_pv, e_pcpu, e_pvec});
        check(rdata == e_rd, "R2/R3/R10 rdata", rdata, e_rd);
        check(err == e_err, "R9 err", {31'b0, err}, {31'b0, e_err});
        wr_en = 0; rd_en = 0; irq = '0; addr = '0; wdata = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1; addr = a; wdata = d; tick();
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_en = 1; addr = a; tick(); d = rdata;
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240607));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(pv == 0 && err == 0, "R1 outputs", {30'b0, pv, err}, 32'h0);
        rd(12'h100, d); check(d == 32'h4, "R1 ctrl", d, 32'h4);
        rd(12'h018, d); check(d == 32'h0, "R1 route", d, 32'h0);

        // R2 route layout, junk bits dropped
        wr(12'h010, 32'hFFFF_F5EA);
        rd(12'h010, d); check(d == 32'h152A, "R2 route", d, 32'h152A);

        // R5 masked pulse dropped
        irq = 8'h04; tick(); tick();
        check(pv == 0, "R5 no post", {31'b0, pv}, 32'h0);
        rd(12'h110, d); check(d == 32'h4, "R5 ctrl", d, 32'h4);

        // R6 unmasked pulse delivered, then auto-masked
        wr(12'h110, 32'h0);
        irq = 8'h04; tick();
        check(pv && pcpu == 5'h15 && pvec == 6'h2A, "R6 post", {20'b0, pv, pcpu, pvec}, {20'b0, 1'b1, 5'h15, 6'h2A});
        tick(); check(pv == 0, "R6 single cycle", {31'b0, pv}, 32'h0);
        rd(12'h110, d); check(d == 32'h5, "R3 ctrl", d, 32'h5);

        // R4 pending kept without bit 1, cleared with it
        wr(12'h110, 32'h4);
        rd(12'h110, d); check(d == 32'h5, "R4 keep pend", d, 32'h5);
        wr(12'h110, 32'h6);
        rd(12'h110, d); check(d == 32'h4, "R4 clear pend", d, 32'h4);

        // R7 same-cycle pulses posted in ascending order
        wr(12'h008, 32'h0111); wr(12'h018, 32'h0313); wr(12'h028, 32'h0515);
        wr(12'h108, 32'h0); wr(12'h118, 32'h0); wr(12'h128, 32'h0);
        irq = 8'h2A; tick();
        check(pv && pvec == 6'h11, "R7 first", {26'b0, pvec}, 32'h11);
        tick(); check(pv && pvec == 6'h13, "R7 second", {26'b0, pvec}, 32'h13);
        tick(); check(pv && pvec == 6'h15, "R7 third", {26'b0, pvec}, 32'h15);

        // R8 last slot in each window
        wr(12'h038, 32'h1F3F);
        rd(12'h038, d); check(d == 32'h1F3F, "R8 route slot 7", d, 32'h1F3F);
        rd(12'h138, d); check(d == 32'h4, "R8 ctrl slot 7", d, 32'h4);

        // R9 unmapped and unaligned
        rd(12'h0C0, d); check(d == 0, "R9 gap read", d, 32'h0);
        rd(12'h104, d); check(d == 0, "R9 unaligned read", d, 32'h0);
        wr(12'h03C, 32'h1F3F); rd(12'h038, d); check(d == 32'h1F3F, "R9 write ignored", d, 32'h1F3F);

        // R11 delivery wins over same-cycle control write
        wr(12'h120, 32'h0);
        wr_en = 1; addr = 12'h120; wdata = 32'h2; irq = 8'h10; tick();
        rd(12'h120, d); check(d == 32'h5, "R11 collision", d, 32'h5);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            int op = $urandom_range(0, 9);
            int ix = $urandom_range(0, N - 1);
            if ($urandom_range(0, 2) == 0) irq = N'($urandom);
            if (op < 3) begin
                wr_en = 1; addr = 12'h100 + 12'(ix * 8);
                wdata = ($urandom_range(0, 3) == 0) ? 32'h4 : ($urandom & 32'h2);
            end else if (op < 4) begin
                wr_en = 1; addr = 12'(ix * 8); wdata = $urandom;
            end else if (op < 7) begin
                rd_en = 1; addr = ($urandom_range(0, 1) == 0) ? 12'(ix * 8) : 12'h100 + 12'(ix * 8);
            end else if (op < 8) begin
                rd_en = 1; addr = 12'($urandom);
            end
            tick();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule